// File: doc/BRIEF.md
# Synchronous Serial I/O Shifter

This block moves one byte at a time over a three-wire clocked serial link. One byte goes out on a data output while another comes in on a data input, and both are timed by a shared serial clock. The serial clock is either produced by the block itself, with a programmable period, or driven by the far end and taken in by the block. On the host side, a byte is written into the transmit shift register and a start strobe begins the transfer. When the transfer ends, the received byte can be read from a holding register and a completion flag is raised.

Bits travel least-significant first. The receive line is sampled on every rising edge of the serial clock. The transmit line keeps its bit for two system clocks after each rising edge and then moves to the next bit, so the far end has almost a full period of setup time. When the block generates the clock, the clock rests high between transfers. When the clock comes from outside, the block passes it through a two-flop synchronizer and finds its rising edges on the system clock. The receive line goes through the same synchronizer depth, so each sampled bit lines up with the edge that was detected.

Top module: `sio_shifter`

## Requirements
- R1: While reset (rstN low) is asserted and right after it: busy=0, done=0, rxData=0, sclkOut=1 and txd=1.
- R2: In internal-clock mode (clkOutMode=1 when start is taken), sclkOut goes low on the start edge. The first rising edge follows H clocks later, and each later rising edge follows 2*H clocks after the one before. H is halfPeriod clamped to the range 8..4096, so the full period is 16..8192 clocks.
- R3: In internal-clock mode, sclkOut is high whenever no transfer is in progress, and sclkOe is 1. In external-clock mode, sclkOe is 0.
- R4: Bit k of the loaded byte (bit 0 first) is on txd at the k-th rising edge of the serial clock. In internal-clock mode, txd holds that bit for exactly 2 clocks after the rising edge and then shows bit k+1.
- R5: rxd is sampled on each rising edge of the serial clock, and the first bit received becomes rxData bit 0. On the clock edge of the eighth rising edge, rxData takes the received byte, busy clears and done sets. rxData does not change at any other time.
- R6: In external-clock mode, rising edges of sclkIn are found after a two-flop synchronizer, and rxd is taken through the same depth. txd moves to the next bit within 5 clocks of an external rising edge, so each bit is valid before the next edge when the period is 16 clocks or more.
- R7: A start strobe takes effect only while busy=0. It sets busy and clears done. Start and txLoad are ignored while busy=1, and txLoad writes txData into the transmit register only while idle.
- R8: Rising edges on sclkIn while no transfer is in progress have no effect: busy, done and rxData stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oscillator) clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkOutMode | input | 1 | 1: block generates the serial clock; 0: serial clock comes from sclkIn |
| halfPeriod | input | 13 | Half period of the generated serial clock in system clocks (clamped to 8..4096) |
| txData | input | 8 | Byte to transmit |
| txLoad | input | 1 | Writes txData into the transmit register when idle |
| start | input | 1 | Begins a transfer when idle |
| rxData | output | 8 | Last received byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Set when a transfer completes, cleared by start |
| sclkIn | input | 1 | External serial clock input |
| sclkOut | output | 1 | Generated serial clock |
| sclkOe | output | 1 | Output enable for the serial clock pad |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |

## Verification
The bench goes after the clamp limits of the half period, at 3 (taken as 8) and at 5000 (taken as 4096). A design that forgot the clamp would show a rising-edge spacing other than 2*H. The bench checks txd on the sample just after each rising edge and again one clock later, which catches a shift that comes too early (no setup hold) or one position off. It pulses start and txLoad in the middle of a transfer; a design that restarted or reloaded would break the edge spacing or the bit stream. It toggles sclkIn while idle; a design that did not gate edges with busy would change rxData or done.

// File: rtl/sio_pkg.sv
package sio_pkg;
  // Strobes from the control to the datapath, valid for one clock.
  typedef struct packed {
    logic load;     // write the transmit register from txData
    logic sample;   // shift one received bit in
    logic shift;    // advance the transmit register by one bit
    logic latch;    // copy the completed byte into the holding register
    logic useSync;  // take rxd from the synchronized path
  } sioStrobe_t;
endpackage

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int BITS     = 8,
  parameter int DIV_W    = 13,
  parameter int HALF_MIN = 8,
  parameter int HALF_MAX = 4096
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkOutMode,
  input  logic [DIV_W-1:0] halfPeriod,
  input  logic             txLoad,
  input  logic             start,
  input  logic             sclkIn,
  output sioStrobe_t       strobe,
  output logic             busy,
  output logic             done,
  output logic             sclkOut,
  output logic             sclkOe
);
  localparam int CNT_W = (BITS > 1) ? $clog2(BITS) : 1;

  logic             modeReg;
  logic [DIV_W-1:0] halfReg;
  logic [DIV_W-1:0] halfClamp;
  logic [DIV_W-1:0] phaseCnt;
  logic [CNT_W-1:0] bitCnt;
  logic [1:0]       shiftPipe;
  logic             sclkS1, sclkS2, sclkS3;
  logic             starting, phaseEnd, intRise, extRise, sampleNow, lastBit;

  always_comb begin
    if (halfPeriod < DIV_W'(HALF_MIN))      halfClamp = DIV_W'(HALF_MIN);
    else if (halfPeriod > DIV_W'(HALF_MAX)) halfClamp = DIV_W'(HALF_MAX);
    else                                    halfClamp = halfPeriod;
  end

  assign starting  = start & ~busy;
  assign phaseEnd  = (phaseCnt == halfReg - DIV_W'(1));
  assign intRise   = modeReg & ~sclkOut & phaseEnd;
  assign extRise   = ~modeReg & sclkS2 & ~sclkS3;
  assign sampleNow = busy & (intRise | extRise);
  assign lastBit   = (bitCnt == CNT_W'(BITS - 1));

  always_comb begin
    strobe.load    = txLoad & ~busy;
    strobe.sample  = sampleNow;
    strobe.shift   = shiftPipe[1] & busy;
    strobe.latch   = sampleNow & lastBit;
    strobe.useSync = ~modeReg;
  end

  assign sclkOe = busy ? modeReg : clkOutMode;

  // Two-flop synchronizer plus one stage for edge detection; idles high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkS1 <= 1'b1;
      sclkS2 <= 1'b1;
      sclkS3 <= 1'b1;
    end else begin
      sclkS1 <= sclkIn;
      sclkS2 <= sclkS1;
      sclkS3 <= sclkS2;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      modeReg   <= 1'b0;
      halfReg   <= DIV_W'(HALF_MIN);
      phaseCnt  <= '0;
      bitCnt    <= '0;
      sclkOut   <= 1'b1;
      shiftPipe <= '0;
    end else begin
      shiftPipe <= starting ? 2'b00 : {shiftPipe[0], sampleNow};
      if (starting) begin
        busy     <= 1'b1;
        done     <= 1'b0;
        modeReg  <= clkOutMode;
        halfReg  <= halfClamp;
        phaseCnt <= '0;
        bitCnt   <= '0;
        sclkOut  <= ~clkOutMode;
      end else if (busy) begin
        if (sampleNow) begin
          bitCnt <= bitCnt + CNT_W'(1);
          if (lastBit) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
        if (modeReg) begin
          if (phaseEnd) begin
            phaseCnt <= '0;
            sclkOut  <= ~sclkOut;
          end else begin
            phaseCnt <= phaseCnt + DIV_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/sio_dpath.sv
module sio_dpath
  import sio_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  sioStrobe_t      strobe,
  input  logic [BITS-1:0] txData,
  input  logic            rxd,
  output logic            txd,
  output logic [BITS-1:0] rxData
);
  logic [BITS-1:0] txShift;
  logic [BITS-1:0] rxShift;
  logic [BITS-1:0] rxNext;
  logic            rxdS1, rxdS2;
  logic            rxBit;

  assign rxBit  = strobe.useSync ? rxdS2 : rxd;
  assign rxNext = {rxBit, rxShift[BITS-1:1]};
  assign txd    = txShift[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxdS1   <= 1'b1;
      rxdS2   <= 1'b1;
      txShift <= '1;
      rxShift <= '0;
      rxData  <= '0;
    end else begin
      rxdS1 <= rxd;
      rxdS2 <= rxdS1;
      if (strobe.load)       txShift <= txData;
      else if (strobe.shift) txShift <= {1'b1, txShift[BITS-1:1]};
      if (strobe.sample)     rxShift <= rxNext;
      if (strobe.latch)      rxData  <= rxNext;
    end
  end
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
  import sio_pkg::*;
#(
  parameter int BITS     = 8,
  parameter int DIV_W    = 13,
  parameter int HALF_MIN = 8,
  parameter int HALF_MAX = 4096
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkOutMode,
  input  logic [DIV_W-1:0] halfPeriod,
  input  logic [BITS-1:0]  txData,
  input  logic             txLoad,
  input  logic             start,
  output logic [BITS-1:0]  rxData,
  output logic             busy,
  output logic             done,
  input  logic             sclkIn,
  output logic             sclkOut,
  output logic             sclkOe,
  output logic             txd,
  input  logic             rxd
);
  sioStrobe_t strobe;

  sio_ctrl #(
    .BITS(BITS), .DIV_W(DIV_W), .HALF_MIN(HALF_MIN), .HALF_MAX(HALF_MAX)
  ) ctrl (
    .clk(clk), .rstN(rstN), .clkOutMode(clkOutMode), .halfPeriod(halfPeriod),
    .txLoad(txLoad), .start(start), .sclkIn(sclkIn), .strobe(strobe),
    .busy(busy), .done(done), .sclkOut(sclkOut), .sclkOe(sclkOe)
  );

  sio_dpath #(.BITS(BITS)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txData(txData),
    .rxd(rxd), .txd(txd), .rxData(rxData)
  );
endmodule

// File: rtl/sio_shifter_chk.sv
module sio_shifter_chk #(
  parameter int BITS  = 8,
  parameter int DIV_W = 13
) (
  input logic             clk,
  input logic             rstN,
  input logic             clkOutMode,
  input logic [DIV_W-1:0] halfPeriod,
  input logic [BITS-1:0]  txData,
  input logic             txLoad,
  input logic             start,
  input logic [BITS-1:0]  rxData,
  input logic             busy,
  input logic             done,
  input logic             sclkIn,
  input logic             sclkOut,
  input logic             sclkOe,
  input logic             txd,
  input logic             rxd
);
  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && clkOutMode) |-> (sclkOut && sclkOe));

  p_done_not_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_rx_stable_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(rxData));

  p_start_sets_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !done));

  p_txd_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sclkOut) && busy) |=> $stable(txd));

  p_ext_oe_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !clkOutMode) |-> !sclkOe);
endmodule

bind sio_shifter sio_shifter_chk #(.BITS(BITS), .DIV_W(DIV_W)) chk (.*);

// File: tb/sio_shifter_test.sv
module sio_shifter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkOutMode = 1'b1;
  logic [12:0] halfPeriod = 13'd8;
  logic [7:0]  txData = 8'h00;
  logic        txLoad = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  rxData;
  logic        busy, done, sclkOut, sclkOe, txd;
  logic        sclkIn = 1'b1;
  logic        rxd = 1'b1;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  sio_shifter uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int clampHalf(input int h);
    if (h < 8) return 8;
    if (h > 4096) return 4096;
    return h;
  endfunction

  // Internal-clock transfer; the bench plays the far end.
  task automatic runOut(input int h, input logic [7:0] tb, input logic [7:0] rb, input bit disturb);
    int heff = clampHalf(h);
    int k = 0;
    int cnt;
    logic prev;
    @(negedge clk); txData = tb; txLoad = 1'b1; clkOutMode = 1'b1; halfPeriod = 13'(h);
    @(negedge clk); txLoad = 1'b0; start = 1'b1; rxd = rb[0];
    @(negedge clk); start = 1'b0; cnt = 1;
    chk("R7 busy after start", {31'd0, busy}, 1);
    chk("R7 done cleared by start", {31'd0, done}, 0);
    chk("R2 sclk low at start", {31'd0, sclkOut}, 0);
    prev = sclkOut;
    while (k < 8) begin
      @(negedge clk); cnt++;
      if (sclkOut && !prev) begin
        chk("R2 rising edge spacing", cnt, (k == 0) ? heff + 1 : 2 * heff);
        chk("R4 txd at rising edge", {31'd0, txd}, {31'd0, tb[k]});
        cnt = 0;
        @(negedge clk); cnt++;
        if (k == 7) begin
          chk("R5 busy cleared", {31'd0, busy}, 0);
          chk("R5 done set", {31'd0, done}, 1);
          chk("R5 rxData", {24'd0, rxData}, {24'd0, rb});
          chk("R3 idle high", {31'd0, sclkOut}, 1);
        end else begin
          rxd = rb[k+1];
          chk("R4 txd held one clock", {31'd0, txd}, {31'd0, tb[k]});
          @(negedge clk); cnt++;
          chk("R4 txd next bit after 2 clocks", {31'd0, txd}, {31'd0, tb[k+1]});
          if (disturb && k == 3) begin
            start = 1'b1; txLoad = 1'b1; txData = ~tb;
            @(negedge clk); cnt++;
            start = 1'b0; txLoad = 1'b0;
          end
        end
        k++;
      end
      prev = sclkOut;
    end
  endtask

  // External-clock transfer; the bench drives sclkIn with half period h.
  task automatic runIn(input int h, input logic [7:0] tb, input logic [7:0] rb);
    @(negedge clk); txData = tb; txLoad = 1'b1; clkOutMode = 1'b0;
    @(negedge clk); txLoad = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R3 oe off in external mode", {31'd0, sclkOe}, 0);
    for (int k = 0; k < 8; k++) begin
      rxd = rb[k]; sclkIn = 1'b0;
      repeat (h) @(negedge clk);
      chk("R6 txd valid before external edge", {31'd0, txd}, {31'd0, tb[k]});
      sclkIn = 1'b1;
      repeat (h) @(negedge clk);
    end
    chk("R5 busy cleared (external)", {31'd0, busy}, 0);
    chk("R5 done set (external)", {31'd0, done}, 1);
    chk("R6 rxData external", {24'd0, rxData}, {24'd0, rb});
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 rxData", {24'd0, rxData}, 0);
    chk("R1 sclkOut", {31'd0, sclkOut}, 1);
    chk("R1 txd", {31'd0, txd}, 1);
    rstN = 1'b1;
    runOut(8, 8'hA5, 8'h3C, 1'b0);
    runOut(3, 8'h81, 8'h7E, 1'b0);           // R2 clamp low
    runOut(20, 8'h5A, 8'hC3, 1'b1);          // R7 start/load mid transfer
    for (int i = 0; i < 6; i++)
      runOut(8 + int'($urandom_range(32)), 8'($urandom), 8'($urandom), 1'($urandom));
    runIn(8, 8'h96, 8'h1F);
    runIn(12, 8'h01, 8'h80);
    for (int i = 0; i < 4; i++)
      runIn(8 + int'($urandom_range(16)), 8'($urandom), 8'($urandom));
    // R8: idle external edges
    begin
      logic [7:0] held;
      held = rxData;
      for (int i = 0; i < 10; i++) begin
        rxd = 1'($urandom); sclkIn = 1'b0;
        repeat (8) @(negedge clk);
        sclkIn = 1'b1;
        repeat (8) @(negedge clk);
      end
      chk("R8 busy stays low", {31'd0, busy}, 0);
      chk("R8 done kept", {31'd0, done}, 1);
      chk("R8 rxData kept", {24'd0, rxData}, {24'd0, held});
    end
    runOut(5000, 8'hE7, 8'h18, 1'b0);        // R2 clamp high
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule